// File: doc/BRIEF.md
# Road-Matching Hit Filter

The filter sits after the cluster-centroid stage of a silicon tracking channel. At the start of each event a table of up to `MAX_ROADS` track roads is loaded, each road being an inclusive window `[lo, hi]` in the same fixed-point units as the centroids. Every centroid that then arrives is compared against every stored road. A centroid inside a road is a hit, and the filter emits one hit word per matching road, carrying the centroid and the road index.

The output is a single valid/ready word stream. Each event's words form a frame: a header first, then the hits, then a trailer. The header reports the event number and how many roads were kept. The trailer reports how many hits were sent. The trailer is only sent after the end-of-event strobe has arrived and every accepted centroid has been scanned. Roads are examined one per clock. Backpressure on the output pauses the scan without losing any centroid.

Top module: `road_hit_filter`

## Requirements
- R1: After reset `out_valid` and `cen_ready` are both low, and no word is produced until an event is opened.
- R2: `evt_start` while no event is open clears the table and opens the load phase. Each `road_valid` cycle in that phase stores one road at the next index, from 0 upward. Loads beyond `MAX_ROADS` (46) are dropped.
- R3: `road_valid` outside the load phase has no effect on the table.
- R4: The load phase closes when a centroid is presented or `evt_end` is seen. A header word is then sent with tag 2'b01 in bits [19:18], the event number in bits [13:6] and the stored road count in bits [5:0].
- R5: A centroid c matches road i exactly when lo_i <= c <= hi_i. Both bounds are inclusive and the comparison is unsigned.
- R6: For each centroid, one hit word is sent per matching road, in ascending road index. The hit word has tag 2'b10 in [19:18], the centroid in [17:6] and the road index in [5:0].
- R7: Only one centroid is held at a time. `cen_ready` is low from the cycle after a centroid is accepted until its scan is complete, and it is never high while `out_valid` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_word` holds its value and `out_valid` stays high. No word or centroid is lost.
- R9: After `evt_end` and after every accepted centroid has been scanned, a trailer is sent with tag 2'b11 in [19:18] and the event's hit count in [15:0]. The block then returns to idle.
- R10: The header's event number starts at 0 after reset and increases by one with each completed trailer.
- R11: `evt_start` while an event is open is ignored. The road table, the hit count and the event number are unaffected.
- R12: Once `evt_end` has been seen, `cen_ready` stays low for the rest of the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_start | input | 1 | Opens a new event (only while idle) |
| evt_end | input | 1 | No more centroids for this event |
| road_valid | input | 1 | Road load strobe |
| road_lo | input | CW | Road lower bound |
| road_hi | input | CW | Road upper bound |
| cen_valid | input | 1 | Centroid offered |
| cen_ready | output | 1 | Centroid accepted this cycle when high with `cen_valid` |
| cen_data | input | CW | Centroid value |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream accepts output word |
| out_word | output | OW | Header, hit or trailer word |

## Verification
On every cycle the assertions check that output words are held under backpressure, that centroid intake and output traffic never overlap, that the road count stays bounded and a full table stays full until the next event, that hit indices fall below the stored road count, and that a trailer handshake leaves the block idle. Which roads actually match, the ascending order of multiple hits, the contents of the header and trailer, and the dropping of late or excess road loads can only be shown by the bench. It sweeps centroids across road edges, overlaps and a full table, with and without backpressure, and compares every word against an arithmetic model.

// File: rtl/hf_pkg.sv
package hf_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_LOAD,
    ST_HDR,
    ST_RUN,
    ST_SCAN,
    ST_TRL
  } hf_state_e;

  localparam logic [1:0] TAG_HDR = 2'b01;
  localparam logic [1:0] TAG_HIT = 2'b10;
  localparam logic [1:0] TAG_TRL = 2'b11;
endpackage

// File: rtl/hf_road_table.sv
module hf_road_table #(
  parameter int CW        = 12,
  parameter int MAX_ROADS = 46,
  parameter int RW        = $clog2(MAX_ROADS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_lo,
  input  logic [CW-1:0] wr_hi,
  input  logic [RW-1:0] rd_idx,
  output logic [CW-1:0] rd_lo,
  output logic [CW-1:0] rd_hi,
  output logic [RW-1:0] count,
  output logic          full
);
  localparam logic [RW-1:0] LIMIT = RW'(MAX_ROADS);

  logic [CW-1:0] lo_mem [MAX_ROADS];
  logic [CW-1:0] hi_mem [MAX_ROADS];
  logic          do_wr;

  assign full  = (count == LIMIT);
  assign do_wr = wr_en && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (do_wr)  count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr && !clr) begin
      lo_mem[count] <= wr_lo;
      hi_mem[count] <= wr_hi;
    end
  end

  always_comb begin
    if (rd_idx < LIMIT) begin
      rd_lo = lo_mem[rd_idx];
      rd_hi = hi_mem[rd_idx];
    end else begin
      rd_lo = '0;
      rd_hi = '0;
    end
  end
endmodule

// File: rtl/hf_scan_ctr.sv
module hf_scan_ctr #(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [RW-1:0] count,
  output logic [RW-1:0] idx,
  output logic          last
);
  assign last = ({1'b0, idx} + 1'b1) >= {1'b0, count};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (step)  idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/road_hit_filter.sv
module road_hit_filter
  import hf_pkg::*;
#(
  parameter int CW        = 12,
  parameter int MAX_ROADS = 46,
  parameter int EVT_W     = 8,
  parameter int HC_W      = 16,
  localparam int RW       = $clog2(MAX_ROADS + 1),
  localparam int HIT_W    = CW + RW,
  localparam int HDR_W    = EVT_W + RW,
  localparam int MAX_A    = (HIT_W > HDR_W) ? HIT_W : HDR_W,
  localparam int PL_W     = (MAX_A > HC_W) ? MAX_A : HC_W,
  localparam int OW       = PL_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_start,
  input  logic          evt_end,
  input  logic          road_valid,
  input  logic [CW-1:0] road_lo,
  input  logic [CW-1:0] road_hi,
  input  logic          cen_valid,
  output logic          cen_ready,
  input  logic [CW-1:0] cen_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_word
);
  function automatic logic in_road(input logic [CW-1:0] c,
                                   input logic [CW-1:0] lo,
                                   input logic [CW-1:0] hi);
    return (lo <= c) && (c <= hi);
  endfunction

  function automatic logic [OW-1:0] mk_hdr(input logic [EVT_W-1:0] ev,
                                           input logic [RW-1:0] nr);
    logic [PL_W-1:0] p;
    p = '0;
    p[HDR_W-1:0] = {ev, nr};
    return {TAG_HDR, p};
  endfunction

  function automatic logic [OW-1:0] mk_hit(input logic [CW-1:0] c,
                                           input logic [RW-1:0] ri);
    logic [PL_W-1:0] p;
    p = '0;
    p[HIT_W-1:0] = {c, ri};
    return {TAG_HIT, p};
  endfunction

  function automatic logic [OW-1:0] mk_trl(input logic [HC_W-1:0] n);
    logic [PL_W-1:0] p;
    p = '0;
    p[HC_W-1:0] = n;
    return {TAG_TRL, p};
  endfunction

  hf_state_e        state, state_nx;
  logic [CW-1:0]    cen_q;
  logic             end_seen;
  logic [HC_W-1:0]  hit_cnt;
  logic [EVT_W-1:0] evt_id;

  logic [RW-1:0]    nroads;
  logic             tbl_full;
  logic [RW-1:0]    scan_idx;
  logic             scan_last;
  logic [CW-1:0]    cur_lo, cur_hi;

  // named internal events
  logic evt_open, road_wr, cen_take, hit_match, scan_step, trl_done;

  assign evt_open  = (state == ST_OFF) && evt_start;
  assign road_wr   = (state == ST_LOAD) && road_valid;
  assign cen_ready = (state == ST_RUN) && !end_seen;
  assign cen_take  = cen_valid && cen_ready;
  assign hit_match = (state == ST_SCAN) && (scan_idx < nroads) &&
                     in_road(cen_q, cur_lo, cur_hi);
  assign scan_step = (state == ST_SCAN) && (!hit_match || out_ready);
  assign trl_done  = (state == ST_TRL) && out_ready;

  hf_road_table #(.CW(CW), .MAX_ROADS(MAX_ROADS), .RW(RW)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (evt_open),
    .wr_en  (road_wr),
    .wr_lo  (road_lo),
    .wr_hi  (road_hi),
    .rd_idx (scan_idx),
    .rd_lo  (cur_lo),
    .rd_hi  (cur_hi),
    .count  (nroads),
    .full   (tbl_full)
  );

  hf_scan_ctr #(.RW(RW)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (scan_step),
    .count (nroads),
    .idx   (scan_idx),
    .last  (scan_last)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_OFF:  if (evt_start) state_nx = ST_LOAD;
      ST_LOAD: if (cen_valid || evt_end) state_nx = ST_HDR;
      ST_HDR:  if (out_ready) state_nx = ST_RUN;
      ST_RUN: begin
        if (cen_take)      state_nx = ST_SCAN;
        else if (end_seen) state_nx = ST_TRL;
      end
      ST_SCAN: if (scan_step && scan_last) state_nx = ST_RUN;
      ST_TRL:  if (out_ready) state_nx = ST_OFF;
      default: state_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      cen_q    <= '0;
      end_seen <= 1'b0;
      hit_cnt  <= '0;
      evt_id   <= '0;
    end else begin
      state <= state_nx;
      if (cen_take) cen_q <= cen_data;
      if (evt_open)                          end_seen <= 1'b0;
      else if (evt_end && state != ST_OFF)   end_seen <= 1'b1;
      if (evt_open)                          hit_cnt <= '0;
      else if (hit_match && out_ready)       hit_cnt <= hit_cnt + 1'b1;
      if (trl_done) evt_id <= evt_id + 1'b1;
    end
  end

  always_comb begin
    out_valid = 1'b0;
    out_word  = '0;
    case (state)
      ST_HDR: begin
        out_valid = 1'b1;
        out_word  = mk_hdr(evt_id, nroads);
      end
      ST_SCAN: begin
        out_valid = hit_match;
        out_word  = hit_match ? mk_hit(cen_q, scan_idx) : '0;
      end
      ST_TRL: begin
        out_valid = 1'b1;
        out_word  = mk_trl(hit_cnt);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hf_checker.sv
module hf_checker #(
  parameter int OW        = 20,
  parameter int RW        = 6,
  parameter int MAX_ROADS = 46
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_word,
  input logic          cen_ready,
  input logic [RW-1:0] nroads,
  input logic          tbl_full,
  input logic          evt_open
);
  logic [1:0] tag;
  assign tag = out_word[OW-1 -: 2];

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  // R7
  cen_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cen_ready |-> !out_valid);

  // R2
  road_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nroads <= RW'(MAX_ROADS));

  // R2
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_full && !evt_open |=> tbl_full);

  // R6
  hit_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && tag == 2'b10 |-> out_word[RW-1:0] < nroads);

  // R9
  trl_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && tag == 2'b11 |=> !out_valid && !cen_ready);
endmodule

bind road_hit_filter hf_checker #(.OW(OW), .RW(RW), .MAX_ROADS(MAX_ROADS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .cen_ready (cen_ready),
  .nroads    (nroads),
  .tbl_full  (tbl_full),
  .evt_open  (evt_open)
);

// File: tb/road_hit_filter_bench.sv
`timescale 1ns/100ps
module road_hit_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_start = 1'b0, evt_end = 1'b0;
  logic        road_valid = 1'b0;
  logic [11:0] road_lo = '0, road_hi = '0;
  logic        cen_valid = 1'b0;
  logic        cen_ready;
  logic [11:0] cen_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] out_word;

  int checks = 0, errors = 0;
  bit bp = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  logic [19:0] exp_q[$];
  string       lbl_q[$];
  int          r_lo[$], r_hi[$], c_list[$];
  int          ev_num = 0;

  always #2.5 clk = ~clk;

  road_hit_filter u_road_hit_filter (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_end(evt_end),
    .road_valid(road_valid), .road_lo(road_lo), .road_hi(road_hi),
    .cen_valid(cen_valid), .cen_ready(cen_ready), .cen_data(cen_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [19:0] w_hdr(input int ev, input int nr);
    return {2'b01, 4'd0, 8'(ev), 6'(nr)};
  endfunction
  function automatic logic [19:0] w_hit(input int c, input int i);
    return {2'b10, 12'(c), 6'(i)};
  endfunction
  function automatic logic [19:0] w_trl(input int n);
    return {2'b11, 2'd0, 16'(n)};
  endfunction

  // output ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready <= bp ? ((cyc % 3) == 2) : 1'b1;
  end

  // monitor: stability under backpressure and word comparison
  logic        pv = 1'b0, pr = 1'b0;
  logic [19:0] pw = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr)
        chk(out_valid && out_word == pw, "R8 hold", out_word, pw);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R9 extra word", out_word, 0);
        else begin
          logic [19:0] e;
          string l;
          e = exp_q.pop_front();
          l = lbl_q.pop_front();
          chk(out_word == e, l, out_word, e);
        end
      end
      pv = out_valid; pr = out_ready; pw = out_word;
    end
  end

  // model of one event from the bench's own road and centroid lists
  task automatic expect_event(input string hl, input string hitl);
    int nr, hits;
    nr = (r_lo.size() > 46) ? 46 : r_lo.size();
    hits = 0;
    exp_q.push_back(w_hdr(ev_num, nr)); lbl_q.push_back({hl, " R4 R10 header"});
    foreach (c_list[k]) begin
      for (int i = 0; i < nr; i++) begin
        if (r_lo[i] <= c_list[k] && c_list[k] <= r_hi[i]) begin
          exp_q.push_back(w_hit(c_list[k], i));
          lbl_q.push_back({hitl, " R5 R6 hit"});
          hits++;
        end
      end
    end
    exp_q.push_back(w_trl(hits)); lbl_q.push_back("R9 trailer");
    ev_num++;
  endtask

  task automatic pulse_start();
    @(negedge clk); evt_start = 1'b1;
    @(negedge clk); evt_start = 1'b0;
  endtask

  task automatic load_road(input int lo, input int hi);
    @(negedge clk); road_valid = 1'b1; road_lo = 12'(lo); road_hi = 12'(hi);
    @(negedge clk); road_valid = 1'b0;
  endtask

  task automatic send_cen(input int c);
    @(negedge clk); cen_valid = 1'b1; cen_data = 12'(c);
    while (!cen_ready) @(negedge clk);
    @(negedge clk); cen_valid = 1'b0;
    chk(!cen_ready, "R7 busy after accept", cen_ready, 0);
  endtask

  task automatic end_and_drain();
    @(negedge clk); evt_end = 1'b1;
    @(negedge clk); evt_end = 1'b0;
    chk(!cen_ready, "R12 closed after end", cen_ready, 0);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(!out_valid, "R9 idle after trailer", out_valid, 0);
  endtask

  task automatic run_event(input string hl, input string hitl);
    expect_event(hl, hitl);
    pulse_start();
    foreach (r_lo[i]) load_road(r_lo[i], r_hi[i]);
    foreach (c_list[k]) send_cen(c_list[k]);
    end_and_drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !cen_ready, "R1 reset outputs", {out_valid, cen_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !cen_ready, "R1 idle before event", {out_valid, cen_ready}, 0);

    // empty event
    r_lo = {}; r_hi = {}; c_list = {};
    run_event("R1", "R6");

    // overlapping roads, full centroid sweep, no backpressure
    r_lo = {10, 15, 30, 5}; r_hi = {20, 15, 40, 12};
    c_list = {};
    for (int c = 0; c < 48; c++) c_list.push_back(c);
    run_event("R5", "R6");

    // same sweep with backpressure
    bp = 1'b1;
    run_event("R8", "R8");
    bp = 1'b0;

    // capacity: 50 loads, 46 kept
    r_lo = {}; r_hi = {};
    for (int i = 0; i < 50; i++) begin r_lo.push_back(i); r_hi.push_back(i + 1); end
    c_list = {0, 45, 46, 47, 48, 100};
    run_event("R2", "R2");

    // late road load and mid-event start are ignored
    r_lo = {100}; r_hi = {200}; c_list = {150, 350};
    expect_event("R3", "R3 R11");
    pulse_start();
    load_road(100, 200);
    send_cen(150);
    load_road(300, 400);
    pulse_start();
    send_cen(350);
    end_and_drain();

    // end arrives while a centroid is still being scanned under backpressure
    bp = 1'b1;
    r_lo = {}; r_hi = {};
    for (int i = 0; i < 8; i++) begin r_lo.push_back(0); r_hi.push_back(4095); end
    c_list = {7};
    expect_event("R10", "R9");
    pulse_start();
    foreach (r_lo[i]) load_road(r_lo[i], r_hi[i]);
    send_cen(7);
    end_and_drain();
    bp = 1'b0;

    chk(exp_q.size() == 0, "R9 all words seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule